// File: doc/BRIEF.md
# Four-Point Radix-2 FFT Datapath

This block computes the discrete Fourier transform of four complex samples. Each sample and each result is an 8-bit word that holds a signed 4-bit real part and a signed 4-bit imaginary part. The transform uses radix-2 decimation in time and has two registered butterfly stages. Between the stages, the only twiddles needed at this size are W0 = 1 and W1 = −j. The −j twiddle is built by swapping the real and imaginary parts and negating one of them, so the block contains no multipliers.

Every butterfly output is halved with rounding. This gives an overall scale of 1/4, and any value that still leaves the nibble range is clamped.

The surrounding logic presents four sample words and pulses `start`. Two clock edges later `done` rises, and the four bin words stay frozen until the next `start`. A small controller sequences the datapath through three states:

- **ST_IDLE**: the state after reset. `done` is low.
- **ST_STAGE1**: the first-stage results are registered.
- **ST_HOLD**: the bins are registered and `done` is high.

The controller has these transitions:

- `start` moves any state to ST_STAGE1. Used in ST_STAGE1, this is a restart.
- ST_STAGE1 moves to ST_HOLD when `start` is absent.
- ST_IDLE and ST_HOLD stay where they are when `start` is absent.

Top module: `fft4_core`

## Requirements
- R1: While `rst_n` is low, `done` is 0 and all four bin words are 0x00.
- R2: Sample and bin words carry the real part in bits 7:4 and the imaginary part in bits 3:0, each a signed two's-complement nibble in the range −8..+7.
- R3: The first stage pairs sample0 with sample2 and sample1 with sample3. Each pair yields half their sum and half their difference, with each component rounded as floor((v+1)/2).
- R4: Bins 1 and 3 use the second-stage twiddle −j on the odd first-stage difference: (re, im) becomes (im, −re). Bins 0 and 2 use the twiddle 1.
- R5: With A0/A1 the sum/difference of pair (0,2) and B0/B1 those of pair (1,3): bin0 is A0+B0, bin2 is A0−B0, bin1 is A1+(−j)B1, and bin3 is A1−(−j)B1. Each is halved with the same rounding as R3.
- R6: Any rounded butterfly component above +7 is output as +7, and any below −8 is output as −8.
- R7: `done` rises on the second rising clock edge after the edge that samples `start` high. The bins are valid at that edge.
- R8: While `done` is high and `start` is low, the bins and `done` hold their values even when the sample inputs change.
- R9: A `start` sampled while `done` is high, or while a transform is in flight, drops `done` on that edge and restarts the transform from the sample inputs present at that edge. Only the last request produces results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising-edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Transform request, sampled on the clock edge |
| sample0 | input | 8 | Time sample 0, packed {re, im} |
| sample1 | input | 8 | Time sample 1, packed {re, im} |
| sample2 | input | 8 | Time sample 2, packed {re, im} |
| sample3 | input | 8 | Time sample 3, packed {re, im} |
| bin0 | output | 8 | Frequency bin 0, packed {re, im} |
| bin1 | output | 8 | Frequency bin 1, packed {re, im} |
| bin2 | output | 8 | Frequency bin 2, packed {re, im} |
| bin3 | output | 8 | Frequency bin 3, packed {re, im} |
| done | output | 1 | High while the bins hold a finished transform |

## Verification
The hardest case to reach from the ports is clamping. Halving each stage keeps almost every input inside the nibble range, so saturation only appears when one pair of samples sits at opposite extremes. That happens, for example, with +7 against −8, where the first-stage difference rounds to +8. The stimulus drives such extreme pairs on purpose, alongside impulses, constants and random words. A second case that is hard to reach is a restart while a transform is in flight. The driver issues `start` on two consecutive edges and expects exactly one result, computed from the second set of samples.

// File: rtl/fft4_pkg.sv
package fft4_pkg;

    localparam int NIB_W  = 4;
    localparam int WORD_W = 2 * NIB_W;
    localparam int NPTS   = 4;
    localparam int HALF   = NPTS / 2;
    localparam int EXT_W  = NIB_W + 1;
    localparam int SUM_W  = EXT_W + 1;
    localparam int RND_W  = SUM_W + 1;

    typedef struct packed {
        logic signed [NIB_W-1:0] re;
        logic signed [NIB_W-1:0] im;
    } cplx_t;

    typedef struct packed {
        logic signed [EXT_W-1:0] re;
        logic signed [EXT_W-1:0] im;
    } cplx_ext_t;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_STAGE1 = 2'd1,
        ST_HOLD   = 2'd2
    } fsm_state_t;

    function automatic cplx_ext_t widen(input cplx_t v);
        cplx_ext_t r;
        r.re = EXT_W'(v.re);
        r.im = EXT_W'(v.im);
        return r;
    endfunction

    // Halve with round-half-up, then clamp into the nibble range.
    function automatic logic [NIB_W-1:0] halve_clamp(input logic signed [SUM_W-1:0] v);
        logic signed [RND_W-1:0] w;
        logic signed [RND_W-1:0] hi;
        logic signed [RND_W-1:0] lo;
        hi = RND_W'((1 << (NIB_W - 1)) - 1);
        lo = -RND_W'(1 << (NIB_W - 1));
        w  = {v[SUM_W-1], v} + RND_W'(1);
        w  = w >>> 1;
        if (w > hi) begin
            w = hi;
        end else if (w < lo) begin
            w = lo;
        end
        return w[NIB_W-1:0];
    endfunction

endpackage

// File: rtl/fft4_bfly.sv
module fft4_bfly
    import fft4_pkg::*;
(
    input  cplx_ext_t a,
    input  cplx_ext_t b,
    output cplx_t     sum_o,
    output cplx_t     dif_o
);

    logic signed [SUM_W-1:0] sum_re;
    logic signed [SUM_W-1:0] sum_im;
    logic signed [SUM_W-1:0] dif_re;
    logic signed [SUM_W-1:0] dif_im;

    always_comb begin
        sum_re = SUM_W'($signed(a.re)) + SUM_W'($signed(b.re));
        sum_im = SUM_W'($signed(a.im)) + SUM_W'($signed(b.im));
        dif_re = SUM_W'($signed(a.re)) - SUM_W'($signed(b.re));
        dif_im = SUM_W'($signed(a.im)) - SUM_W'($signed(b.im));
        sum_o.re = halve_clamp(sum_re);
        sum_o.im = halve_clamp(sum_im);
        dif_o.re = halve_clamp(dif_re);
        dif_o.im = halve_clamp(dif_im);
    end

endmodule

// File: rtl/fft4_twiddle.sv
module fft4_twiddle
    import fft4_pkg::*;
#(
    parameter int unsigned K = 0
) (
    input  cplx_t     x,
    output cplx_ext_t y
);

    cplx_ext_t xw;
    assign xw = widen(x);

    generate
        if (K == 0) begin : g_unity
            assign y = xw;
        end else begin : g_minus_j
            // (re + j im) * (-j) = im - j re
            assign y.re = xw.im;
            assign y.im = -xw.re;
        end
    endgenerate

endmodule

// File: rtl/fft4_ctrl.sv
module fft4_ctrl
    import fft4_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic ld_stage1,
    output logic ld_bins,
    output logic done
);

    fsm_state_t state_q;
    fsm_state_t state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = ST_STAGE1;
            ST_STAGE1: state_d = start ? ST_STAGE1 : ST_HOLD;
            ST_HOLD:   if (start) state_d = ST_STAGE1;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        ld_stage1 = start;
        ld_bins   = 1'b0;
        done      = 1'b0;
        unique case (state_q)
            ST_IDLE:   ;
            ST_STAGE1: ld_bins = !start;
            ST_HOLD:   done = 1'b1;
            default:   ;
        endcase
    end

endmodule

// File: rtl/fft4_core.sv
module fft4_core
    import fft4_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [7:0] sample0,
    input  logic [7:0] sample1,
    input  logic [7:0] sample2,
    input  logic [7:0] sample3,
    output logic [7:0] bin0,
    output logic [7:0] bin1,
    output logic [7:0] bin2,
    output logic [7:0] bin3,
    output logic       done
);

    cplx_t smp [NPTS];
    cplx_t s1_d [NPTS];
    cplx_t s1_q [NPTS];
    cplx_t bin_d [NPTS];
    cplx_t bin_q [NPTS];
    logic  ld_stage1;
    logic  ld_bins;

    assign smp[0] = cplx_t'(sample0);
    assign smp[1] = cplx_t'(sample1);
    assign smp[2] = cplx_t'(sample2);
    assign smp[3] = cplx_t'(sample3);

    fft4_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .ld_stage1 (ld_stage1),
        .ld_bins   (ld_bins),
        .done      (done)
    );

    // Stage 1: bit-reversed pairs (p, p+HALF); slot 2p = sum, 2p+1 = difference.
    generate
        for (genvar p = 0; p < HALF; p++) begin : g_stage1
            fft4_bfly u_bf (
                .a     (widen(smp[p])),
                .b     (widen(smp[p+HALF])),
                .sum_o (s1_d[2*p]),
                .dif_o (s1_d[2*p+1])
            );
        end
    endgenerate

    // Stage 2: A_k = s1_q[k], B_k = s1_q[HALF+k] rotated by W^k.
    generate
        for (genvar k = 0; k < HALF; k++) begin : g_stage2
            cplx_ext_t b_rot;
            fft4_twiddle #(.K(k)) u_tw (
                .x (s1_q[HALF+k]),
                .y (b_rot)
            );
            fft4_bfly u_bf (
                .a     (widen(s1_q[k])),
                .b     (b_rot),
                .sum_o (bin_d[k]),
                .dif_o (bin_d[k+HALF])
            );
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NPTS; i++) begin
                s1_q[i] <= '0;
            end
        end else if (ld_stage1) begin
            for (int i = 0; i < NPTS; i++) begin
                s1_q[i] <= s1_d[i];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NPTS; i++) begin
                bin_q[i] <= '0;
            end
        end else if (ld_bins) begin
            for (int i = 0; i < NPTS; i++) begin
                bin_q[i] <= bin_d[i];
            end
        end
    end

    assign bin0 = WORD_W'(bin_q[0]);
    assign bin1 = WORD_W'(bin_q[1]);
    assign bin2 = WORD_W'(bin_q[2]);
    assign bin3 = WORD_W'(bin_q[3]);

endmodule

// File: rtl/fft4_checker.sv
module fft4_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic [7:0] bin0,
    input logic [7:0] bin1,
    input logic [7:0] bin2,
    input logic [7:0] bin3,
    input logic       done
);

    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (!done && bin0 == 8'h00 && bin1 == 8'h00 && bin2 == 8'h00 && bin3 == 8'h00));

    p_done_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n, 2) && $past(rst_n) && $past(start, 2) && !$past(start)) |-> done);

    p_start_drops_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !done);

    p_hold_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && $stable(bin0) && $stable(bin1) && $stable(bin2) && $stable(bin3)));

    p_done_needs_request_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> (!$past(start) && $past(rst_n)));

endmodule

bind fft4_core fft4_checker u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .bin0  (bin0),
    .bin1  (bin1),
    .bin2  (bin2),
    .bin3  (bin3),
    .done  (done)
);

// File: tb/tb_fft4_core.sv
module tb_fft4_core;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       start;
    logic [7:0] sample0, sample1, sample2, sample3;
    logic [7:0] bin0, bin1, bin2, bin3;
    logic       done;

    always #5 clk = ~clk;

    fft4_core dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .sample0(sample0), .sample1(sample1), .sample2(sample2), .sample3(sample3),
        .bin0(bin0), .bin1(bin1), .bin2(bin2), .bin3(bin3), .done(done)
    );

    int n_chk  = 0;
    int n_fail = 0;
    bit reported = 0;

    logic [31:0] exp_q[$];
    string       tag_q[$];

    int edge_cnt  = 0;
    int st_edge   = 0;
    logic done_prev = 1'b0;

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        end
    endtask

    // Reference model built from R2..R6.
    function automatic int hc(input int v);
        int t;
        t = (v + 1) >>> 1;
        if (t > 7) t = 7;
        if (t < -8) t = -8;
        return t;
    endfunction

    function automatic int nre(input logic [7:0] w);
        return int'($signed(w[7:4]));
    endfunction

    function automatic int nim(input logic [7:0] w);
        return int'($signed(w[3:0]));
    endfunction

    function automatic logic [7:0] pk(input int re, input int im);
        logic [3:0] r4, i4;
        r4 = 4'(re);
        i4 = 4'(im);
        return {r4, i4};
    endfunction

    function automatic logic [31:0] model(input logic [31:0] x);
        logic [7:0] s0, s1, s2, s3;
        int a0r, a0i, a1r, a1i, b0r, b0i, b1r, b1i, tr, ti;
        s0 = x[7:0]; s1 = x[15:8]; s2 = x[23:16]; s3 = x[31:24];
        a0r = hc(nre(s0) + nre(s2)); a0i = hc(nim(s0) + nim(s2));
        a1r = hc(nre(s0) - nre(s2)); a1i = hc(nim(s0) - nim(s2));
        b0r = hc(nre(s1) + nre(s3)); b0i = hc(nim(s1) + nim(s3));
        b1r = hc(nre(s1) - nre(s3)); b1i = hc(nim(s1) - nim(s3));
        tr = b1i; ti = -b1r;
        return {pk(hc(a1r - tr), hc(a1i - ti)), pk(hc(a0r - b0r), hc(a0i - b0i)),
                pk(hc(a1r + tr), hc(a1i + ti)), pk(hc(a0r + b0r), hc(a0i + b0i))};
    endfunction

    // Edge bookkeeping for latency (R7).
    always @(posedge clk) begin
        if (start) st_edge = edge_cnt;
        edge_cnt++;
    end

    // Monitor: pops the scoreboard when done rises.
    always @(negedge clk) begin
        if (rst_n && done && !done_prev) begin
            if (exp_q.size() == 0) begin
                check("R9", "unexpected done", 1, 0);
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check("R7", {t, " latency"}, edge_cnt - st_edge, 2);
                check("R5", {t, " bin0"}, bin0, e[7:0]);
                check("R4", {t, " bin1"}, bin1, e[15:8]);
                check("R5", {t, " bin2"}, bin2, e[23:16]);
                check("R4", {t, " bin3"}, bin3, e[31:24]);
            end
        end
        done_prev = done;
    end

    task automatic drive(input logic [31:0] x);
        sample0 = x[7:0]; sample1 = x[15:8]; sample2 = x[23:16]; sample3 = x[31:24];
    endtask

    // Driver: issues one transform and queues its expected bins.
    task automatic run(input logic [31:0] x, input string tag);
        @(negedge clk);
        drive(x);
        start = 1'b1;
        exp_q.push_back(model(x));
        tag_q.push_back(tag);
        @(negedge clk);
        start = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    function automatic logic [31:0] xs(input logic [7:0] a, input logic [7:0] b,
                                        input logic [7:0] c, input logic [7:0] d);
        return {d, c, b, a};
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
        $finish;
    end

    initial begin
        logic [31:0] held;
        rst_n = 1'b0;
        start = 1'b0;
        drive(32'h0);
        repeat (3) @(negedge clk);
        check("R1", "done in reset", done, 0);
        check("R1", "bins in reset", {bin3, bin2, bin1, bin0}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2/R3: impulses at slot 0 and slot 1, with known packed values.
        run(xs(8'h3E, 8'h00, 8'h00, 8'h00), "impulse0 R3");
        run(xs(8'h00, 8'h62, 8'h00, 8'h00), "impulse1 R4");
        // R2: constants, positive and the most negative code.
        run(xs(8'h55, 8'h55, 8'h55, 8'h55), "const_pos R2");
        run(xs(8'h88, 8'h88, 8'h88, 8'h88), "const_neg R2");
        // Explicit packing check: impulse (4, 4) at sample0 gives every bin (1, 1).
        run(xs(8'h44, 8'h00, 8'h00, 8'h00), "pack R2");
        check("R2", "bin0 packed", bin0, 8'h11);
        check("R2", "bin3 packed", bin3, 8'h11);
        // R6: opposite extremes force a first-stage difference of +8, clamped to +7.
        run(xs(8'h77, 8'h00, 8'h88, 8'h00), "sat_a R6");
        check("R6", "bin1 clamp", bin1, 8'h44);
        run(xs(8'h77, 8'h77, 8'h88, 8'h88), "sat_b R6");

        // R8: changing samples while holding must not move the bins.
        run(xs(8'h12, 8'h34, 8'hA5, 8'hF7), "hold R8");
        held = {bin3, bin2, bin1, bin0};
        drive(xs(8'h7F, 8'h80, 8'h3C, 8'hC3));
        repeat (4) @(negedge clk);
        check("R8", "done held", done, 1);
        check("R8", "bins held", {bin3, bin2, bin1, bin0}, held);

        // R9: start on two consecutive edges; only the second set counts.
        @(negedge clk);
        drive(xs(8'h70, 8'h70, 8'h70, 8'h70));
        start = 1'b1;
        @(negedge clk);
        check("R9", "done dropped", done, 0);
        drive(xs(8'h1F, 8'h2E, 8'h3D, 8'h4C));
        exp_q.push_back(model(xs(8'h1F, 8'h2E, 8'h3D, 8'h4C)));
        tag_q.push_back("restart R9");
        @(negedge clk);
        start = 1'b0;
        check("R9", "no early done", done, 0);
        repeat (2) @(negedge clk);

        for (int i = 0; i < 40; i++) begin
            run($urandom(), "random R5");
        end

        repeat (3) @(negedge clk);
        check("R5", "scoreboard drained", exp_q.size(), 0);
        report();
        $finish;
    end

endmodule